// File: doc/BRIEF.md
# Processor Reset Entry Sequencer

This block carries a processor core from reset to its first instruction fetch. While the synchronous active-low reset is held, it forces the status word, the vector base and the stack and program counter registers to fixed values. It also clears the enables of the memories attached to the core and abandons any read that is still in flight. Reset overrides everything else the block is doing.

On the first clock edge after reset is released, the block latches two hardware-configuration words meant for data registers 0 and 1. One bit of the first word reports whether a hardware divider is fitted. The block then makes two longword reads over a simple request/ready bus. The word at address 0 becomes the supervisor stack pointer and the word at address 4 becomes the program counter. If both reads are clean and both vectors are longword aligned, the block raises `fetch_go` and the core begins fetching at `pc`. A bus error, or a vector with either of its low two bits set, sends the block into a halted double-fault state that only reset can clear.

Top module: `rst_entry_seq`

## Requirements
- R1: At every clock edge where `rst_n` is low, the block abandons any pending read. On the following cycle `bus_req`, `fetch_go`, `halted` and `cfg_valid` are 0, and `ssp` and `pc` are 0.
- R2: After reset, `sr_word` is 0x2700: bit 13 (supervisor) is 1, bit 15 (trace) is 0, bit 12 (master state) is 0, bits 10:8 (interrupt mask) are 111, and every other bit is 0. The value holds until the next reset.
- R3: After reset, `vbr` is 0x00000000 and stays there.
- R4: After reset, every bit of `mem_ctl_en` is 0.
- R5: The first clock edge with `rst_n` high latches the configuration words, and `cfg_valid` reads 1 from the next cycle on. `cfg_word0` equals `strap_cfg0` with bit DIV_POS (24 by default) replaced by `div_present`. `cfg_word1` equals `strap_cfg1`. Later changes to the strap inputs do not affect either word.
- R6: The block reads address 0 first and address 4 second. `bus_req` stays high with a stable `bus_addr` until a cycle with `bus_ready` or `bus_err`, however long that takes.
- R7: A clean beat at address 0 loads `bus_rdata` into `ssp`. A clean beat at address 4 loads it into `pc`.
- R8: After a clean, aligned read of the program counter, `fetch_go` rises and stays high. From then on `pc` is longword aligned.
- R9: `bus_err` on either beat leaves that beat's register unloaded and sends the block to `halted`. `bus_err` takes priority over a simultaneous `bus_ready`.
- R10: A vector whose bits 1:0 are nonzero is still loaded, but the block halts. A misaligned stack pointer stops the sequence before the second read.
- R11: Once `halted` is set, it stays set and `fetch_go` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (the core reset input) |
| strap_cfg0 | input | 32 | Configuration value for data register 0 |
| strap_cfg1 | input | 32 | Configuration value for data register 1 |
| div_present | input | 1 | 1 when a hardware divider is fitted |
| bus_req | output | 1 | Read request, held until ready or error |
| bus_addr | output | 32 | Read address (0 or 4) |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Read beat complete |
| bus_err | input | 1 | Read beat failed (access error) |
| sr_word | output | 16 | Status register value |
| vbr | output | 32 | Vector base register |
| ssp | output | 32 | Supervisor stack pointer |
| pc | output | 32 | Program counter, first fetch address |
| cfg_word0 | output | 32 | Configuration word for data register 0 |
| cfg_word1 | output | 32 | Configuration word for data register 1 |
| cfg_valid | output | 1 | Configuration words latched |
| mem_ctl_en | output | 2 | Enables of the attached memory controls |
| fetch_go | output | 1 | Instruction fetch may begin at pc |
| halted | output | 1 | Double-fault halt |

## Verification
Two pairs of events can land in the same cycle. The first pair is an access error and a ready on one beat. The bench's bus model raises both together on the program-counter read, and the check requires a halt with `pc` still zero. The second pair is reset and a pending read. The bench asserts `rst_n` while the address-4 request is waiting on a long latency. It then checks on the next cycle that the request has dropped and that both loaded registers are back to zero, and a normal sequence that follows must complete.

// File: rtl/rst_seq_pkg.sv
// Shared types and status-word layout for the reset entry sequencer.
// Assumes a 16-bit status word with the field positions given below.
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_CAPT  = 3'd0,
        ST_RD_SP = 3'd1,
        ST_RD_PC = 3'd2,
        ST_RUN   = 3'd3,
        ST_HALT  = 3'd4
    } seq_state_t;

    localparam int SR_W      = 16;
    localparam int SR_T_POS  = 15;
    localparam int SR_S_POS  = 13;
    localparam int SR_M_POS  = 12;
    localparam int SR_IM_LO  = 8;
    localparam int SR_IM_W   = 3;

    // Builds the status word value that reset forces.
    function automatic logic [SR_W-1:0] sr_reset_value();
        logic [SR_W-1:0] v;
        v = '0;
        v[SR_S_POS] = 1'b1;
        v[SR_T_POS] = 1'b0;
        v[SR_M_POS] = 1'b0;
        v[SR_IM_LO +: SR_IM_W] = '1;
        return v;
    endfunction

endpackage

// File: rtl/rst_vec_reader.sv
// Vector read port: turns the controller's read phase into a bus request
// and classifies each returned beat as a clean load or a fault.
// Assumes the bus answers with at most one of ready/err being meaningful;
// when both are high the error wins.
module rst_vec_reader #(
    parameter int DATA_W  = 32,
    parameter int ALIGN_W = 2
) (
    input  logic               active,
    input  logic               sel_pc,
    input  logic [ALIGN_W-1:0] rdata_low,
    input  logic               ready,
    input  logic               err,
    output logic               bus_req,
    output logic [DATA_W-1:0]  bus_addr,
    output logic               beat_load,
    output logic               beat_fault
);
    localparam int STRIDE = DATA_W / 8;

    logic aligned;

    // Request and address follow the controller's read phase.
    always_comb begin
        bus_req  = active;
        bus_addr = sel_pc ? DATA_W'(STRIDE) : '0;
    end

    // Classify the returned beat: load on ready, fault on error or misalignment.
    always_comb begin
        aligned    = (rdata_low == '0);
        beat_load  = active && ready && !err;
        beat_fault = active && (err || (ready && !aligned));
    end

endmodule

// File: rtl/rst_cfg_latch.sv
// Configuration word latch: on the capture pulse, takes one snapshot of the
// strap words, with the divider-present flag merged into word 0, and holds it.
// Assumes capture is a single-cycle pulse after reset release.
module rst_cfg_latch #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 2,
    parameter int DIV_POS   = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             capture,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] strap_in,
    input  logic                             div_present,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] word_out,
    output logic                             valid
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] merged;
        logic [DATA_W-1:0] word_q;

        // Form the value to latch; word 0 carries the divider flag.
        always_comb begin
            merged = strap_in[w];
            if (w == 0) begin
                merged[DIV_POS] = div_present;
            end
        end

        // Hold the snapshot from the capture cycle on.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (capture) begin
                word_q <= merged;
            end
        end

        assign word_out[w] = word_q;
    end

    // Mark the words as latched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (capture) begin
            valid <= 1'b1;
        end
    end

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (valid && $stable(word_out)));

endmodule

// File: rtl/rst_seq_ctrl.sv
// Reset entry controller: steps from configuration capture through the
// stack pointer and program counter reads to run or the double-fault halt.
// It also owns the registers that reset forces.
// Assumes beat_load/beat_fault are valid only while a read phase is active.
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_CTL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat_load,
    input  logic                 beat_fault,
    input  logic [DATA_W-1:0]    rdata,
    output logic                 capture,
    output logic                 rd_active,
    output logic                 sel_pc,
    output logic [SR_W-1:0]      sr_word,
    output logic [DATA_W-1:0]    vbr,
    output logic [DATA_W-1:0]    ssp,
    output logic [DATA_W-1:0]    pc,
    output logic [MEM_CTL_W-1:0] mem_ctl_en,
    output logic                 fetch_go,
    output logic                 halted
);
    localparam logic [SR_W-1:0] SR_RST = sr_reset_value();

    seq_state_t state;

    // Sequence state: capture, two reads, then run or halt for good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CAPT;
        end else begin
            unique case (state)
                ST_CAPT:  state <= ST_RD_SP;
                ST_RD_SP: begin
                    if (beat_fault)     state <= ST_HALT;
                    else if (beat_load) state <= ST_RD_PC;
                end
                ST_RD_PC: begin
                    if (beat_fault)     state <= ST_HALT;
                    else if (beat_load) state <= ST_RUN;
                end
                ST_RUN:   state <= ST_RUN;
                ST_HALT:  state <= ST_HALT;
                default:  state <= ST_HALT;
            endcase
        end
    end

    // Load the stack pointer from the first beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssp <= '0;
        end else if (state == ST_RD_SP && beat_load) begin
            ssp <= rdata;
        end
    end

    // Load the program counter from the second beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (state == ST_RD_PC && beat_load) begin
            pc <= rdata;
        end
    end

    // Status word, vector base and memory enables are forced by reset and then held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_word    <= SR_RST;
            vbr        <= '0;
            mem_ctl_en <= '0;
        end else begin
            sr_word    <= sr_word;
            vbr        <= vbr;
            mem_ctl_en <= mem_ctl_en;
        end
    end

    // Decode phase strobes and the externally visible state.
    always_comb begin
        capture   = (state == ST_CAPT);
        rd_active = (state == ST_RD_SP) || (state == ST_RD_PC);
        sel_pc    = (state == ST_RD_PC);
        fetch_go  = (state == ST_RUN);
        halted    = (state == ST_HALT);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_active && !fetch_go && !halted && ssp == '0 && pc == '0));

    // R2
    sr_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (sr_word == SR_RST && vbr == '0));

    // R8
    fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> (pc[1:0] == 2'b00 && !halted));

    // R9
    fault_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && beat_fault) |=> halted);

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !fetch_go));

endmodule

// File: rtl/rst_entry_seq.sv
// Reset entry sequencer top: wires the controller, the vector read port
// and the configuration latch together.
// Assumes rst_n is already synchronous to clk.
module rst_entry_seq
    import rst_seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DIV_POS   = 24,
    parameter int MEM_CTL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    strap_cfg0,
    input  logic [DATA_W-1:0]    strap_cfg1,
    input  logic                 div_present,
    output logic                 bus_req,
    output logic [DATA_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_rdata,
    input  logic                 bus_ready,
    input  logic                 bus_err,
    output logic [SR_W-1:0]      sr_word,
    output logic [DATA_W-1:0]    vbr,
    output logic [DATA_W-1:0]    ssp,
    output logic [DATA_W-1:0]    pc,
    output logic [DATA_W-1:0]    cfg_word0,
    output logic [DATA_W-1:0]    cfg_word1,
    output logic                 cfg_valid,
    output logic [MEM_CTL_W-1:0] mem_ctl_en,
    output logic                 fetch_go,
    output logic                 halted
);
    localparam int NUM_CFG = 2;
    localparam int ALIGN_W = $clog2(DATA_W / 8);

    logic capture, rd_active, sel_pc, beat_load, beat_fault;
    logic [NUM_CFG-1:0][DATA_W-1:0] strap_bus;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_bus;

    // Pack the straps and unpack the latched words.
    always_comb begin
        strap_bus[0] = strap_cfg0;
        strap_bus[1] = strap_cfg1;
        cfg_word0    = cfg_bus[0];
        cfg_word1    = cfg_bus[1];
    end

    rst_seq_ctrl #(
        .DATA_W    (DATA_W),
        .MEM_CTL_W (MEM_CTL_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_load  (beat_load),
        .beat_fault (beat_fault),
        .rdata      (bus_rdata),
        .capture    (capture),
        .rd_active  (rd_active),
        .sel_pc     (sel_pc),
        .sr_word    (sr_word),
        .vbr        (vbr),
        .ssp        (ssp),
        .pc         (pc),
        .mem_ctl_en (mem_ctl_en),
        .fetch_go   (fetch_go),
        .halted     (halted)
    );

    rst_vec_reader #(
        .DATA_W  (DATA_W),
        .ALIGN_W (ALIGN_W)
    ) i_reader (
        .active     (rd_active),
        .sel_pc     (sel_pc),
        .rdata_low  (bus_rdata[ALIGN_W-1:0]),
        .ready      (bus_ready),
        .err        (bus_err),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .beat_load  (beat_load),
        .beat_fault (beat_fault)
    );

    rst_cfg_latch #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_CFG),
        .DIV_POS   (DIV_POS)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .strap_in    (strap_bus),
        .div_present (div_present),
        .word_out    (cfg_bus),
        .valid       (cfg_valid)
    );

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready && !bus_err) |=> (bus_req && $stable(bus_addr)));

endmodule

// File: tb/test_rst_entry_seq.sv
// Scoreboard bench: run_case pushes the expected outcome of one reset
// sequence into a queue, and a monitor pops it when run or halt appears.
module test_rst_entry_seq;
    localparam int DW = 32;
    localparam int DIVP = 24;

    typedef struct packed {
        logic [31:0] ssp;
        logic [31:0] pc;
        logic        halt;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] strap0 = '0, strap1 = '0;
    logic div_p = 1'b0;
    logic bus_req, bus_ready = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_addr, bus_rdata = '0;
    logic [15:0] sr_word;
    logic [31:0] vbr, ssp, pc, cfg0, cfg1;
    logic cfg_valid, fetch_go, halted;
    logic [1:0] mem_en;

    int checks = 0, fails = 0;
    exp_t q[$];
    bit seen = 1'b1;

    // bus model settings
    logic [31:0] m_sp, m_pc;
    int lat = 0, lat_cnt = 0;
    int err_sel = 0;
    bit both = 1'b0;

    always #5 clk = ~clk;

    rst_entry_seq #(.DATA_W(DW), .DIV_POS(DIVP), .MEM_CTL_W(2)) i_rst_entry_seq (
        .clk(clk), .rst_n(rst_n), .strap_cfg0(strap0), .strap_cfg1(strap1),
        .div_present(div_p), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
        .sr_word(sr_word), .vbr(vbr), .ssp(ssp), .pc(pc),
        .cfg_word0(cfg0), .cfg_word1(cfg1), .cfg_valid(cfg_valid),
        .mem_ctl_en(mem_en), .fetch_go(fetch_go), .halted(halted)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus responder: answers after lat waiting cycles; checks the address (R6).
    always @(negedge clk) begin
        bus_ready = 1'b0;
        bus_err   = 1'b0;
        if (bus_req) begin
            chk(bus_addr == 32'h0 || bus_addr == 32'h4, "R6 addr", bus_addr, 32'h0);
            if (lat_cnt >= lat) begin
                lat_cnt = 0;
                bus_rdata = (bus_addr == 32'h4) ? m_pc : m_sp;
                if ((err_sel == 1 && bus_addr == 32'h0) || (err_sel == 2 && bus_addr == 32'h4)) begin
                    bus_err = 1'b1;
                    bus_ready = both;
                end else begin
                    bus_ready = 1'b1;
                end
            end else begin
                lat_cnt++;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // Monitor: compare the end state against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && !seen && (fetch_go || halted)) begin
            exp_t e;
            seen = 1'b1;
            if (q.size() == 0) begin
                chk(1'b0, "R8 scoreboard empty", 32'h0, 32'h1);
            end else begin
                e = q.pop_front();
                chk(ssp == e.ssp, "R7 ssp", ssp, e.ssp);
                chk(pc == e.pc, "R7 pc", pc, e.pc);
                chk(halted == e.halt, "R9 R10 halted", {31'b0, halted}, {31'b0, e.halt});
                chk(fetch_go == !e.halt, "R8 fetch_go", {31'b0, fetch_go}, {31'b0, !e.halt});
                chk(sr_word == 16'h2700, "R2 sr held", {16'b0, sr_word}, 32'h2700);
                chk(vbr == 32'h0, "R3 vbr held", vbr, 32'h0);
            end
        end
    end

    task automatic hold_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sr_word == 16'h2700, "R2 sr reset", {16'b0, sr_word}, 32'h2700);
        chk(vbr == 32'h0, "R3 vbr reset", vbr, 32'h0);
        chk(mem_en == 2'b00, "R4 mem enables", {30'b0, mem_en}, 32'h0);
        chk(!bus_req && !fetch_go && !halted && !cfg_valid, "R1 quiet in reset",
            {28'b0, bus_req, fetch_go, halted, cfg_valid}, 32'h0);
    endtask

    task automatic run_case(input logic [31:0] sp, input logic [31:0] pcv, input int l,
                            input int es, input bit bth, input bit dv,
                            input logic [31:0] c0, input logic [31:0] c1);
        exp_t e;
        logic [31:0] x0;
        int n;
        hold_reset();
        m_sp = sp; m_pc = pcv; lat = l; err_sel = es; both = bth;
        div_p = dv; strap0 = c0; strap1 = c1;
        e.ssp = '0; e.pc = '0; e.halt = 1'b1;
        if (es != 1) begin
            e.ssp = sp;
            if (sp[1:0] == 2'b00) begin
                if (es != 2) begin
                    e.pc = pcv;
                    e.halt = (pcv[1:0] != 2'b00);
                end
            end
        end
        q.push_back(e);
        seen = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        x0 = c0; x0[DIVP] = dv;
        chk(cfg_valid, "R5 cfg_valid", {31'b0, cfg_valid}, 32'h1);
        chk(cfg0 == x0, "R5 cfg0", cfg0, x0);
        chk(cfg1 == c1, "R5 cfg1", cfg1, c1);
        strap0 = ~c0; strap1 = ~c1; div_p = ~dv;
        n = 0;
        while (!seen && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(seen, "R6 sequence completes", n, 32'd500);
        repeat (4) @(negedge clk);
        chk(halted == e.halt && fetch_go == !e.halt, "R11 end state sticky",
            {30'b0, halted, fetch_go}, {30'b0, e.halt, !e.halt});
        chk(cfg0 == x0 && cfg1 == c1, "R5 straps ignored", cfg0, x0);
    endtask

    // Reset arrives while the address-4 read is still pending (R1).
    task automatic abort_case();
        int n;
        hold_reset();
        m_sp = 32'h0000_3000; m_pc = 32'h0000_0100; lat = 40; err_sel = 0; both = 0;
        seen = 1'b1;
        rst_n = 1'b1;
        n = 0;
        while (!(bus_req && bus_addr == 32'h4) && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(ssp == 32'h0000_3000, "R7 ssp before abort", ssp, 32'h0000_3000);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!bus_req && !fetch_go && !halted, "R1 read abandoned",
            {29'b0, bus_req, fetch_go, halted}, 32'h0);
        chk(ssp == 32'h0 && pc == 32'h0, "R1 vectors cleared", ssp, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // clean sequences, different latencies and divider flags
        run_case(32'h2000_1000, 32'h0000_0400, 0, 0, 0, 1'b1, 32'h1234_5678, 32'hCAFE_0001);
        run_case(32'h0000_1FFC, 32'h8000_0010, 3, 0, 0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000);
        // R9 error on stack pointer beat, and error together with ready on the pc beat
        run_case(32'h0000_2000, 32'h0000_0200, 1, 1, 0, 1'b1, 32'h0, 32'h5);
        run_case(32'h0000_2000, 32'h0000_0200, 2, 2, 1, 1'b0, 32'hA5A5_A5A5, 32'h7);
        // R10 misaligned stack pointer, then misaligned program counter
        run_case(32'h0000_1002, 32'h0000_0400, 0, 0, 0, 1'b1, 32'h0, 32'h0);
        run_case(32'h0000_1000, 32'h0000_0403, 0, 0, 0, 1'b0, 32'h0100_0000, 32'h9);
        // R1 abort mid-read, then a normal sequence after it
        abort_case();
        run_case(32'h0040_0000, 32'h0000_0800, 1, 0, 0, 1'b1, 32'h0, 32'h1);
        // R6 long wait for ready
        run_case(32'h0000_0010, 32'h0000_0020, 25, 0, 0, 1'b0, 32'h0, 32'h2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule